// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two integers of a configurable width (32 bits by default) over one cycle per multiplier bit, using a single adder only one operand wide. A combined product register, twice the operand width, starts with the multiplier in its lower half and zero in its upper half. Each cycle the block examines bit 0 of that register. When the bit is set, it adds the multiplicand into the upper half. It then shifts the whole register one place to the right, so the next multiplier bit moves into bit 0. The multiplicand register is loaded once and never shifts.

Operands enter through a valid/ready handshake. A transfer happens on a rising edge where `in_valid` and `in_ready` are both high, and `in_ready` stays low for the whole operation. A caller that holds `in_valid` high while the block is busy is simply not served until the block becomes ready again, and the operands, mode and valid it presents in that time have no effect. The result side has no back-pressure. `done` pulses for one cycle, and the product stays on `res_hi`/`res_lo` until the next transfer is accepted. A mode bit captured with the operands selects unsigned or two's-complement arithmetic. In signed mode the partial product is sign-extended, and the last step subtracts the multiplicand instead of adding it, because the multiplier's top bit carries negative weight.

Top module: `seqmul_shiftadd`

## Requirements
- R1: After reset, `done` is 0, `in_ready` is 1 and both `res_hi` and `res_lo` are 0.
- R2: With `in_signed`=0 at acceptance, {`res_hi`,`res_lo`} equals the unsigned product of `in_a` and `in_b`, including the carry out of the adder on every step.
- R3: With `in_signed`=1 at acceptance, {`res_hi`,`res_lo`} equals the two's-complement product of `in_a` and `in_b`, including operands at the most negative value.
- R4: `done` goes high exactly WIDTH clock cycles after the accepting edge and stays high for exactly one cycle.
- R5: `in_ready` is 0 from the accepting edge until `done` rises. `in_valid`, `in_a` and `in_b` presented during that time do not change the result and start no extra operation.
- R6: After `done`, `res_hi`/`res_lo` hold their value unchanged until a new transfer is accepted.
- R7: The mode is captured at acceptance. Toggling `in_signed` while busy does not change the result.
- R8: `in_ready` is 1 in the cycle `done` is high, so a new transfer can be accepted on the next edge with no idle cycle between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block is idle and accepts an operand pair |
| in_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| in_a | input | WIDTH | Multiplicand |
| in_b | input | WIDTH | Multiplier |
| done | output | 1 | One-cycle pulse when the product is ready |
| res_hi | output | WIDTH | Upper half of the product |
| res_lo | output | WIDTH | Lower half of the product |

## Verification
The bench builds one instance with WIDTH=4 and sweeps every operand pair in both modes. That reaches every carry-out pattern and every mix of signs, including -8 times -8 and -8 times 7, and checks the exact latency and the hold behaviour for each operation. A second instance at the default WIDTH=32 runs directed corner cases: all-ones operands, the most negative value against itself and against one, zero, and mixed patterns. During some operations the bench flips the operands, mode and valid mid-flight, and some operations are chained directly onto the previous `done`.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mul_mode_e;

  // Control for one add/shift step
  typedef struct packed {
    logic      add_en;  // multiplier bit under test is 1
    logic      sub_en;  // last step of signed mode: subtract instead
    mul_mode_e mode;
  } step_ctl_t;

endpackage

// File: rtl/seqmul_addsub.sv
module seqmul_addsub
  import seqmul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  step_ctl_t        ctl_i,
  output logic [WIDTH:0]   sum_o
);

  logic [WIDTH:0] acc_x;
  logic [WIDTH:0] mcand_x;
  logic           sext;

  assign sext    = (ctl_i.mode == MODE_SIGNED);
  assign acc_x   = {sext & acc_i[WIDTH-1], acc_i};
  assign mcand_x = {sext & mcand_i[WIDTH-1], mcand_i};

  always_comb begin
    if (ctl_i.add_en && ctl_i.sub_en)
      sum_o = acc_x - mcand_x;
    else if (ctl_i.add_en)
      sum_o = acc_x + mcand_x;
    else
      sum_o = acc_x;
  end

endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  output logic busy_o,
  output logic last_o,
  output logic done_o
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [CW-1:0] step_cnt;

  assign last_o = busy_o && (step_cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      step_cnt <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept_i) begin
        busy_o   <= 1'b1;
        step_cnt <= '0;
      end else if (busy_o) begin
        if (last_o) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                               // R4
  AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (done_o && !busy_o));                                   // R4
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (step_cnt <= LAST_IDX));                                // R4

endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath
  import seqmul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               last_i,
  input  mul_mode_e          mode_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [2*WIDTH-1:0] prod_o
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  mul_mode_e        mode_q;
  logic [PW-1:0]    prod_q;
  step_ctl_t        ctl;
  logic [WIDTH:0]   sum;

  assign ctl.add_en = prod_q[0];
  assign ctl.sub_en = last_i && (mode_q == MODE_SIGNED);
  assign ctl.mode   = mode_q;

  seqmul_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc_i   (prod_q[PW-1:WIDTH]),
    .mcand_i (mcand_q),
    .ctl_i   (ctl),
    .sum_o   (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      mode_q  <= MODE_UNSIGNED;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= a_i;
      mode_q  <= mode_i;
      prod_q  <= {{WIDTH{1'b0}}, b_i};
    end else if (step_i) begin
      prod_q  <= {sum, prod_q[WIDTH-1:1]};
    end
  end

  assign prod_o = prod_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(prod_q));                         // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !last_i) |=> $stable(mode_q));                          // R7

endmodule

// File: rtl/seqmul_shiftadd.sv
module seqmul_shiftadd
  import seqmul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_signed,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             done,
  output logic [WIDTH-1:0] res_hi,
  output logic [WIDTH-1:0] res_lo
);

  logic               busy;
  logic               last;
  logic               accept;
  logic [2*WIDTH-1:0] prod;
  mul_mode_e          mode_sel;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign mode_sel = in_signed ? MODE_SIGNED : MODE_UNSIGNED;

  seqmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .busy_o   (busy),
    .last_o   (last),
    .done_o   (done)
  );

  seqmul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .step_i (busy),
    .last_i (last),
    .mode_i (mode_sel),
    .a_i    (in_a),
    .b_i    (in_b),
    .prod_o (prod)
  );

  assign res_hi = prod[2*WIDTH-1:WIDTH];
  assign res_lo = prod[WIDTH-1:0];

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!in_ready && !done));                                  // R5
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));                                             // R4
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);                                                // R8

endmodule

// File: tb/sim_seqmul_shiftadd.sv
`timescale 1ns/1ps
module sim_seqmul_shiftadd;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // WIDTH=4 instance: exhaustive sweep
  logic       s_valid = 1'b0, s_signed = 1'b0;
  logic [3:0] s_a = '0, s_b = '0;
  logic       s_ready, s_done;
  logic [3:0] s_hi, s_lo;

  seqmul_shiftadd #(.WIDTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_ready(s_ready),
    .in_signed(s_signed), .in_a(s_a), .in_b(s_b), .done(s_done),
    .res_hi(s_hi), .res_lo(s_lo)
  );

  // WIDTH=32 instance: directed corners
  logic        w_valid = 1'b0, w_signed = 1'b0;
  logic [31:0] w_a = '0, w_b = '0;
  logic        w_ready, w_done;
  logic [31:0] w_hi, w_lo;

  seqmul_shiftadd #(.WIDTH(32)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(w_valid), .in_ready(w_ready),
    .in_signed(w_signed), .in_a(w_a), .in_b(w_b), .done(w_done),
    .res_hi(w_hi), .res_lo(w_lo)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input int w, input logic sgn,
                                           input logic [63:0] a, input logic [63:0] b);
    logic [63:0] lowmask = (64'd1 << w) - 64'd1;
    logic [63:0] pmask   = (w >= 32) ? '1 : ((64'd1 << (2 * w)) - 64'd1);
    logic [63:0] xa = a & lowmask;
    logic [63:0] xb = b & lowmask;
    if (sgn && xa[w-1]) xa = xa | ~lowmask;
    if (sgn && xb[w-1]) xb = xb | ~lowmask;
    return (xa * xb) & pmask;
  endfunction

  // Caller is at a negedge; returns at a negedge.
  task automatic op4(input logic sgn, input logic [3:0] a, input logic [3:0] b,
                     input bit disturb, input bit chain);
    logic [63:0] exp = ref_prod(4, sgn, {60'd0, a}, {60'd0, b});
    bit lat_ok = 1'b1;
    logic [7:0] res;
    chk(s_ready === 1'b1, "R8 ready before start", {63'd0, s_ready}, 64'd1);
    s_valid = 1'b1; s_signed = sgn; s_a = a; s_b = b;
    @(negedge clk);                      // accepting edge passed
    s_valid = disturb; s_signed = disturb ? ~sgn : sgn;
    if (disturb) begin s_a = ~a; s_b = a ^ b; end
    if (s_done !== 1'b0 || s_ready !== 1'b0) lat_ok = 1'b0;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      if (k == 3) s_valid = 1'b0;
      if (s_done !== 1'b0 || s_ready !== 1'b0) lat_ok = 1'b0;
    end
    @(negedge clk);                      // 4 edges after accept
    chk(lat_ok && s_done === 1'b1, "R4/R5 latency and busy", {63'd0, s_done}, 64'd1);
    res = {s_hi, s_lo};
    chk(res === exp[7:0], sgn ? "R3 signed product w4" : "R2 unsigned product w4",
        {56'd0, res}, exp);
    if (disturb)
      chk(res === exp[7:0], "R7 mode/operand change while busy", {56'd0, res}, exp);
    if (!chain) begin
      @(negedge clk);
      chk(s_done === 1'b0 && {s_hi, s_lo} === res, "R6 result held, done one cycle",
          {55'd0, s_done, s_hi, s_lo}, {56'd0, res});
    end
  endtask

  task automatic op32(input logic sgn, input logic [31:0] a, input logic [31:0] b,
                      input bit disturb);
    logic [63:0] exp = ref_prod(32, sgn, {32'd0, a}, {32'd0, b});
    bit lat_ok = 1'b1;
    w_valid = 1'b1; w_signed = sgn; w_a = a; w_b = b;
    @(negedge clk);
    w_valid = disturb; w_signed = disturb ? ~sgn : sgn;
    if (disturb) begin w_a = b; w_b = a ^ 32'h5A5A_5A5A; end
    for (int k = 1; k < 32; k++) begin
      if (w_done !== 1'b0 || w_ready !== 1'b0) lat_ok = 1'b0;
      @(negedge clk);
      if (k == 31) w_valid = 1'b0;
    end
    if (w_done !== 1'b0) lat_ok = 1'b0;
    @(negedge clk);
    chk(lat_ok && w_done === 1'b1, "R4/R5 latency w32", {63'd0, w_done}, 64'd1);
    chk({w_hi, w_lo} === exp, sgn ? "R3 signed product w32" : "R2 unsigned product w32",
        {w_hi, w_lo}, exp);
    @(negedge clk);
    chk(w_done === 1'b0 && {w_hi, w_lo} === exp, "R6 hold w32", {w_hi, w_lo}, exp);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] va [10];
    logic [31:0] vb [10];
    va[0] = 32'hFFFF_FFFF; vb[0] = 32'hFFFF_FFFF;
    va[1] = 32'h8000_0000; vb[1] = 32'h8000_0000;
    va[2] = 32'h8000_0000; vb[2] = 32'h0000_0001;
    va[3] = 32'h0000_0001; vb[3] = 32'h8000_0000;
    va[4] = 32'h7FFF_FFFF; vb[4] = 32'h8000_0000;
    va[5] = 32'h0000_0000; vb[5] = 32'hDEAD_BEEF;
    va[6] = 32'h1234_5678; vb[6] = 32'h9ABC_DEF0;
    va[7] = 32'hDEAD_BEEF; vb[7] = 32'h0BAD_F00D;
    va[8] = 32'h7FFF_FFFF; vb[8] = 32'h7FFF_FFFF;
    va[9] = 32'hFFFF_FFFF; vb[9] = 32'h0000_0002;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_done === 1'b0 && s_ready === 1'b1 && {s_hi, s_lo} === 8'd0,
        "R1 reset state w4", {54'd0, s_done, s_ready, s_hi, s_lo}, 64'h100);
    chk(w_done === 1'b0 && w_ready === 1'b1 && {w_hi, w_lo} === 64'd0,
        "R1 reset state w32", {w_hi, w_lo}, 64'd0);

    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          op4(m[0], a[3:0], b[3:0], ((a + b) % 5) == 0, b == 15);

    // R8: chained operation right after done
    op4(1'b1, 4'h8, 4'h8, 1'b0, 1'b1);
    op4(1'b0, 4'hF, 4'hF, 1'b0, 1'b0);

    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 10; i++)
        op32(m[0], va[i], vb[i], (i % 3) == 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule